// File: doc/BRIEF.md
# Lossless Delta Sample Compressor

This block shrinks a stream of 12-bit samples that arrive in time order, one channel after another. For each sample it takes the difference from the previous sample of the same channel. When that difference is small and common, the block emits a short prefix code, and it packs these codes back to back into 16-bit output words. When the difference is too large to have a code, it sends the sample unchanged in a word of its own. The two top bits of every output word are a header that tells a receiver how to read the other 14 bits.

A sample marked as the start of a channel always goes out unchanged, and it resets the predictor. A packed word that is still open is emitted before any unchanged word. Because of this, a new channel start also closes the last packed word of the previous channel. A stream of slowly changing waveforms can reach a ratio of up to 14 samples per word. A receiver rebuilds the exact samples by adding up the decoded differences.

Top module: `dcmp_compressor`

## Requirements
- R1: A sample with `in_start` high leaves as one word with header 2'b10, the sample in bits [11:0] and zeros in bits [13:12]. Header 2'b11 never appears.
- R2: The differences 0, +1, -1, +2 and -2 are coded as "1", "01", "001", "0001" and "00001". Codes are placed most significant bit first, starting at bit 13 of a word with header 2'b01.
- R3: Any other difference produces one word with header 2'b00, the sample in bits [11:0] and zeros in bits [13:12].
- R4: An open packed word is emitted when the next code does not fit in its 14 payload bits. Payload bits that are not used are zero.
- R5: Fourteen zero differences in a row fill exactly one word, 16'h7FFF. That word is emitted only when the next word is needed.
- R6: A start or unchanged sample that arrives while a packed word is open first emits that packed word, then its own word.
- R7: The difference is always taken from the previous accepted sample, including samples sent unchanged. The first sample after reset that has no start flag is sent as a 2'b00 word.
- R8: Words leave in stream order, at most one per cycle. Each word appears no earlier than the cycle after the input that completed it. The block absorbs back-to-back input without loss.
- R9: During and just after reset, `out_valid` is low and no packed word is open.
- R10: Decoding the output restores every input sample exactly, and never yields more words than samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_start | input | 1 | The offered sample begins a new channel |
| in_sample | input | 12 | Sample value |
| out_valid | output | 1 | `out_word` holds a word this cycle |
| out_word | output | 16 | Output word: 2-bit header and 14-bit body |

## Verification
A predictor that holds the wrong previous value shows up right away. The next coded word carries a wrong prefix, or an unchanged word appears where a code was expected, and a decoder drifts from that sample on. A wrong fill count moves codes across bit positions, or closes a word one code early or late. This is seen at the next channel start, when the word is emitted. Words are compared exactly against hand-derived hex values, and the round trip on long random walks catches any error that builds up over time.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
    localparam int HDR_W = 2;

    localparam logic [HDR_W-1:0] HDR_RAW   = 2'b00;
    localparam logic [HDR_W-1:0] HDR_PACK  = 2'b01;
    localparam logic [HDR_W-1:0] HDR_START = 2'b10;

    typedef enum logic [1:0] {
        K_CODE  = 2'd0,
        K_RAW   = 2'd1,
        K_START = 2'd2
    } kind_e;
endpackage

// File: rtl/dcmp_delta_code.sv
module dcmp_delta_code
    import dcmp_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int MAX_CODE_LEN = 5,
    parameter int LEN_W        = $clog2(MAX_CODE_LEN + 1)
) (
    input  logic                in_start,
    input  logic                pred_ok,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] prev,
    output kind_e               kind,
    output logic [LEN_W-1:0]    len
);
    localparam int WL_W = SAMPLE_W + 2;
    localparam logic [WL_W-1:0] MAX_L = WL_W'(MAX_CODE_LEN);

    logic signed [SAMPLE_W:0] diff;
    logic        [SAMPLE_W:0] mag;
    logic        [WL_W-1:0]   word_len;
    logic                     has_code;

    always_comb begin
        diff = signed'({1'b0, sample}) - signed'({1'b0, prev});
        mag  = diff[SAMPLE_W] ? SAMPLE_W'(0) - diff : diff;
        // zero -> 1, +m -> 2m, -m -> 2m+1 : prefix of (len-1) zeros then a one
        if (diff == '0) begin
            word_len = WL_W'(1);
        end else begin
            word_len = {mag, 1'b0} + WL_W'(diff[SAMPLE_W]);
        end
        has_code = (word_len <= MAX_L);

        if (in_start) begin
            kind = K_START;
        end else if (!pred_ok || !has_code) begin
            kind = K_RAW;
        end else begin
            kind = K_CODE;
        end
        len = word_len[LEN_W-1:0];
    end
endmodule

// File: rtl/dcmp_word_pack.sv
module dcmp_word_pack
    import dcmp_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int WORD_W       = 16,
    parameter int MAX_CODE_LEN = 5,
    parameter int LEN_W        = $clog2(MAX_CODE_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  kind_e               kind,
    input  logic [LEN_W-1:0]    len,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word
);
    localparam int PAY_W  = WORD_W - HDR_W;
    localparam int FILL_W = $clog2(PAY_W + 1);
    localparam int PAD_W  = PAY_W - SAMPLE_W;
    localparam logic [FILL_W:0]  PAY_L = (FILL_W + 1)'(PAY_W);
    localparam logic [PAY_W-1:0] ONE   = PAY_W'(1);

    typedef struct packed {
        logic [PAY_W-1:0]  acc;
        logic [FILL_W-1:0] fill;
        logic              out_v;
        logic [WORD_W-1:0] out_w;
        logic              skid_v;
        logic [WORD_W-1:0] skid_w;
    } pack_st_t;

    pack_st_t st_d, st_q;

    logic              new0_v, new1_v;
    logic [WORD_W-1:0] new0_w, new1_w;
    logic [WORD_W-1:0] pack_word, raw_word;
    logic [FILL_W:0]   len_x, sum;

    always_comb begin
        st_d      = st_q;
        new0_v    = 1'b0;
        new1_v    = 1'b0;
        new0_w    = '0;
        new1_w    = '0;
        pack_word = {HDR_PACK, st_q.acc};
        raw_word  = {(kind == K_START) ? HDR_START : HDR_RAW, {PAD_W{1'b0}}, sample};
        len_x     = (FILL_W + 1)'(len);
        sum       = (FILL_W + 1)'(st_q.fill) + len_x;

        if (in_valid) begin
            if (kind == K_CODE) begin
                if (sum > PAY_L) begin
                    new0_v      = 1'b1;
                    new0_w      = pack_word;
                    st_d.acc    = ONE << (PAY_L - len_x);
                    st_d.fill   = len_x[FILL_W-1:0];
                end else begin
                    st_d.acc    = st_q.acc | (ONE << (PAY_L - sum));
                    st_d.fill   = sum[FILL_W-1:0];
                end
            end else begin
                if (st_q.fill != '0) begin
                    new0_v = 1'b1;
                    new0_w = pack_word;
                    new1_v = 1'b1;
                    new1_w = raw_word;
                end else begin
                    new0_v = 1'b1;
                    new0_w = raw_word;
                end
                st_d.acc  = '0;
                st_d.fill = '0;
            end
        end

        if (st_q.skid_v) begin
            st_d.out_v  = 1'b1;
            st_d.out_w  = st_q.skid_w;
            st_d.skid_v = new0_v;
            st_d.skid_w = new0_w;
        end else begin
            st_d.out_v  = new0_v;
            st_d.out_w  = new0_w;
            st_d.skid_v = new1_v;
            st_d.skid_w = new1_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_v;
    assign out_word  = st_q.out_w;

    // R8
    skid_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.skid_v |-> !new1_v);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FILL_W + 1)'(st_q.fill) <= PAY_L);

    // R4
    packed_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[WORD_W-1 -: HDR_W] == HDR_PACK) |-> out_word[PAY_W-1:0] != '0);

    // R1
    header_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1 -: HDR_W] != 2'b11);

    // R3
    raw_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[WORD_W-1 -: HDR_W] != HDR_PACK) |-> out_word[PAY_W-1:SAMPLE_W] == '0);
endmodule

// File: rtl/dcmp_compressor.sv
module dcmp_compressor
    import dcmp_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int WORD_W       = 16,
    parameter int MAX_CODE_LEN = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_start,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_word
);
    localparam int LEN_W = $clog2(MAX_CODE_LEN + 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] prev;
        logic                ok;
    } pred_st_t;

    pred_st_t         pred_d, pred_q;
    kind_e            kind;
    logic [LEN_W-1:0] len;

    always_comb begin
        pred_d = pred_q;
        if (in_valid) begin
            pred_d.prev = in_sample;
            pred_d.ok   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            pred_q <= pred_d;
        end
    end

    dcmp_delta_code #(
        .SAMPLE_W    (SAMPLE_W),
        .MAX_CODE_LEN(MAX_CODE_LEN),
        .LEN_W       (LEN_W)
    ) u_code (
        .in_start(in_start),
        .pred_ok (pred_q.ok),
        .sample  (in_sample),
        .prev    (pred_q.prev),
        .kind    (kind),
        .len     (len)
    );

    dcmp_word_pack #(
        .SAMPLE_W    (SAMPLE_W),
        .WORD_W      (WORD_W),
        .MAX_CODE_LEN(MAX_CODE_LEN),
        .LEN_W       (LEN_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .kind     (kind),
        .len      (len),
        .sample   (in_sample),
        .out_valid(out_valid),
        .out_word (out_word)
    );

    // R7
    first_after_reset_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_start && !pred_q.ok) |-> kind == K_RAW);
endmodule

// File: tb/dcmp_compressor_test.sv
module dcmp_compressor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_start = 1'b0;
    logic [11:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] got[$];
    int sent[$];

    always #4 clk = ~clk;

    dcmp_compressor uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_sample(in_sample), .out_valid(out_valid), .out_word(out_word)
    );

    always @(negedge clk) if (rst_n && out_valid) got.push_back(out_word);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input bit st, input int s);
        @(negedge clk);
        in_valid  = 1'b1;
        in_start  = st;
        in_sample = s[11:0];
        sent.push_back(s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
        end
    endtask

    task automatic expect_words(input string req, input logic [15:0] exp[$]);
        idle(4);
        check(got.size() == exp.size(), {req, " word count"}, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] === exp[i], req, got[i], exp[i]);
        got.delete();
        sent.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R9: no output while in reset
        check(out_valid == 1'b0, "R9 reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 after reset", out_valid, 0);
        got.delete();
        sent.delete();
    endtask

    // R5 R6 R1: fourteen repeats fill one word, closed by next start
    task automatic t_full_word();
        push(1, 100);
        for (int i = 0; i < 14; i++) push(0, 100);
        push(1, 7);
        expect_words("R5 full word", '{16'h8064, 16'h7FFF, 16'h8007});
    endtask

    // R2 R4: all five codes, overflow on the sixth
    task automatic t_codes();
        push(1, 500);
        push(0, 501);
        push(0, 500);
        push(0, 502);
        push(0, 500);
        push(0, 500);
        push(1, 12'h123);
        expect_words("R2 R4 codes", '{16'h81F4, 16'h5221, 16'h6000, 16'h8123});
    endtask

    // R3 R6 R7: raw words flush pending code and re-seed the predictor
    task automatic t_raw();
        push(1, 1000);
        push(0, 1001);
        push(0, 1004);
        push(0, 1004);
        push(0, 999);
        push(1, 0);
        expect_words("R3 R7 raw", '{16'h83E8, 16'h5000, 16'h03EC, 16'h6000, 16'h03E7, 16'h8000});
    endtask

    // R3: range extremes and a difference of three
    task automatic t_extremes();
        push(1, 0);
        push(0, 4095);
        push(0, 4092);
        push(0, 4094);
        push(1, 5);
        expect_words("R3 extremes", '{16'h8000, 16'h0FFF, 16'h0FFC, 16'h4400, 16'h8005});
    endtask

    // R7 R8: no start after reset, with idle gaps between samples
    task automatic t_no_start();
        do_reset();
        push(0, 77);
        idle(2);
        push(0, 77);
        idle(3);
        push(1, 1);
        expect_words("R7 R8 no start", '{16'h004D, 16'h6000, 16'h8001});
    endtask

    // R10 R8: random slow waveforms, decoded back
    task automatic t_round_trip();
        int dec[$];
        int prev;
        int v;
        int r;
        int nsamp;
        prev = 0;
        for (int ch = 0; ch < 8; ch++) begin
            v = $urandom_range(0, 4095);
            push(1, v);
            for (int k = 0; k < $urandom_range(20, 300); k++) begin
                r = $urandom_range(0, 99);
                if (r < 40)      v = v;
                else if (r < 55) v = v + 1;
                else if (r < 70) v = v - 1;
                else if (r < 78) v = v + 2;
                else if (r < 86) v = v - 2;
                else if (r < 93) v = v + $urandom_range(3, 9);
                else if (r < 97) v = v - $urandom_range(3, 9);
                else             v = $urandom_range(0, 4095);
                if (v < 0) v = 0;
                if (v > 4095) v = 4095;
                push(0, v);
            end
        end
        push(1, 0);
        idle(4);
        foreach (got[i]) begin
            if (got[i][15:14] == 2'b01) begin
                int zeros;
                zeros = 0;
                for (int b = 13; b >= 0; b--) begin
                    if (got[i][b]) begin
                        int L;
                        L = zeros + 1;
                        if (L == 1)          prev = prev;
                        else if (L % 2 == 0) prev = prev + L / 2;
                        else                 prev = prev - (L - 1) / 2;
                        dec.push_back(prev);
                        zeros = 0;
                    end else begin
                        zeros++;
                    end
                end
            end else begin
                prev = got[i][11:0];
                dec.push_back(prev);
            end
        end
        nsamp = sent.size();
        check(dec.size() == nsamp, "R10 decoded count", dec.size(), nsamp);
        check(got.size() <= nsamp, "R10 words not above samples", got.size(), nsamp);
        for (int i = 0; i < nsamp && i < dec.size(); i++)
            check(dec[i] == sent[i], "R10 round trip", dec[i], sent[i]);
        got.delete();
        sent.delete();
    endtask

    initial begin
        do_reset();
        t_full_word();
        t_codes();
        t_raw();
        t_extremes();
        t_no_start();
        t_round_trip();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1200000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule